// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block listens to the command pins of an SDRAM interface on every rising clock edge. It keeps a model of four banks: whether each bank is open, and the cycle timers that each bank needs. It does not drive the memory. It only reports. A command that breaks a bank-state rule or a minimum spacing sets one bit in a sticky violation vector. The code of the first offending command since the last clear is stored next to that vector.

The guard sits beside a memory controller in simulation or on silicon debug logic. It turns a timing slip into a flag that names the rule at once, instead of data corruption many cycles later. Every limit is a module parameter counted in clock cycles. The defaults match a 6 ns clock: tRCD 3, tRAS 7, tRP 3, tRC 10, tRRD 2, tWR 2, tRSC 2.

Top module: `sdram_rule_guard`

## Requirements
- R1: With cs_n low, the pin levels {ras_n,cas_n,we_n} decode as follows:
  - 011 is activate (code 2).
  - 101 is read (code 3).
  - 100 is write (code 4).
  - 010 is precharge (code 5).
  - 001 is auto refresh (code 6).
  - 000 is mode register set (code 7).
  - 110 is burst stop (code 8).
  - 111 is no-operation (code 0).
  - cs_n high is deselect (code 1).
  An activate to an idle bank sets that bank's bit in `bank_open` one clock after the command edge.
- R2: A precharge closes the addressed open bank, or every open bank when a10 is high. A read or write with a10 high closes its bank. A precharge to a bank that is already idle changes neither state nor timers.
- R3: A read or write to an open bank fewer than T_RCD cycles after that bank's activate sets flag bit 0.
- R4: A precharge that reaches an open bank sets flag bit 1 if that bank was activated fewer than T_RAS cycles earlier. It sets flag bit 5 if that bank was written fewer than T_WR cycles earlier.
- R5: An activate to an idle bank sets flag bit 2 if the bank is still in its precharge window. That window is T_RP cycles after a precharge or a read with auto-precharge, and T_WR+T_RP cycles after a write with auto-precharge.
- R6: An activate to an idle bank sets flag bit 3 if it comes fewer than T_RC cycles after that bank's last activate or after any auto refresh.
- R7: An activate that opens a bank sets flag bit 4 if it comes fewer than T_RRD cycles after the previous bank-opening activate.
- R8: Two bank-state errors set flag bit 6: a read or write to an idle bank, or an activate to an open bank. Neither one changes state. A mode register set or auto refresh while any bank is open sets flag bit 7.
- R9: Any command other than no-operation or deselect, issued fewer than T_RSC cycles after a mode register set, sets flag bit 8.
- R10: Flag bits stay set until `viol_clear` is high at a clock edge. Clearing drops the old bits, while violations of the same cycle are still recorded. `viol_cmd` takes the command code of a violation that lands on an empty or cleared vector and holds it otherwise. Reset gives all-zero outputs.
- R11: Burst stop, no-operation and deselect never change bank state and never set a flag, except for bit 8 as given in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| cmd_bank | input | 2 | Bank select |
| cmd_a10 | input | 1 | All-banks flag for precharge, auto-precharge flag for read/write |
| viol_clear | input | 1 | Clears the sticky flags at the clock edge |
| bank_open | output | 4 | One bit per bank, high while the bank is open |
| viol_flags | output | 9 | Sticky rule-violation bits |
| viol_cmd | output | 4 | Code of the first command that set a flag since the last clear |

## Verification
A wrong bank state shows up on `bank_open` one clock after the command. Unlike a timer error, it also produces a false state flag (bit 6) on the next read, write or activate to that bank. A timer that is loaded with the wrong value, or never loaded, stays hidden until a command lands inside its window. The stimulus therefore places commands exactly one cycle inside and exactly at each boundary. Examples are an activate on the first legal tRC cycle and an activate one cycle short of the tWR+tRP window that follows a write with auto-precharge. The result appears on `viol_flags` at the edge that samples the command.

// File: rtl/sdram_chk_pkg.sv
`timescale 1ns/1ps
package sdram_chk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_REF   = 4'd6,
    CMD_MRS   = 4'd7,
    CMD_BST   = 4'd8
  } cmd_e;

  localparam int RULE_RCD   = 0;
  localparam int RULE_RAS   = 1;
  localparam int RULE_RP    = 2;
  localparam int RULE_RC    = 3;
  localparam int RULE_RRD   = 4;
  localparam int RULE_WR    = 5;
  localparam int RULE_STATE = 6;
  localparam int RULE_IDLE  = 7;
  localparam int RULE_RSC   = 8;
  localparam int RULE_COUNT = 9;

  function automatic int span_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_hold_timer.sv
`timescale 1ns/1ps
module sdram_hold_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy = (remain_q != '0);

endmodule

// File: rtl/sdram_bank_track.sv
`timescale 1ns/1ps
module sdram_bank_track #(
  parameter int T_RCD = 3,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int T_WR  = 2,
  parameter int W     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic do_act,
  input  logic do_pre,
  input  logic do_rd,
  input  logic do_wr,
  input  logic do_auto,
  input  logic do_ref,
  output logic is_open,
  output logic rcd_busy,
  output logic ras_busy,
  output logic rp_busy,
  output logic rc_busy,
  output logic wr_busy
);

  localparam logic [W-1:0] RCD_LD    = W'(T_RCD - 1);
  localparam logic [W-1:0] RAS_LD    = W'(T_RAS - 1);
  localparam logic [W-1:0] RP_LD     = W'(T_RP - 1);
  localparam logic [W-1:0] RP_WAP_LD = W'(T_WR + T_RP - 1);
  localparam logic [W-1:0] RC_LD     = W'(T_RC - 1);
  localparam logic [W-1:0] WR_LD     = W'(T_WR - 1);

  logic         auto_close;
  logic         rp_load;
  logic [W-1:0] rp_val;
  logic         open_q;

  assign auto_close = (do_rd | do_wr) & do_auto;
  assign rp_load    = do_pre | auto_close;
  assign rp_val     = (do_wr & do_auto) ? RP_WAP_LD : RP_LD;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else if (do_act) begin
      open_q <= 1'b1;
    end else if (rp_load) begin
      open_q <= 1'b0;
    end
  end

  assign is_open = open_q;

  sdram_hold_timer #(.W(W)) u_rcd (
    .clk(clk), .rst(rst), .load(do_act), .load_val(RCD_LD), .busy(rcd_busy)
  );

  sdram_hold_timer #(.W(W)) u_ras (
    .clk(clk), .rst(rst), .load(do_act), .load_val(RAS_LD), .busy(ras_busy)
  );

  sdram_hold_timer #(.W(W)) u_rp (
    .clk(clk), .rst(rst), .load(rp_load), .load_val(rp_val), .busy(rp_busy)
  );

  sdram_hold_timer #(.W(W)) u_rc (
    .clk(clk), .rst(rst), .load(do_act | do_ref), .load_val(RC_LD), .busy(rc_busy)
  );

  sdram_hold_timer #(.W(W)) u_wr (
    .clk(clk), .rst(rst), .load(do_wr), .load_val(WR_LD), .busy(wr_busy)
  );

endmodule

// File: rtl/sdram_rule_guard.sv
`timescale 1ns/1ps
module sdram_rule_guard
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_RSC     = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_cs_n,
  input  logic                  cmd_ras_n,
  input  logic                  cmd_cas_n,
  input  logic                  cmd_we_n,
  input  logic [BANK_W-1:0]     cmd_bank,
  input  logic                  cmd_a10,
  input  logic                  viol_clear,
  output logic [NUM_BANKS-1:0]  bank_open,
  output logic [RULE_COUNT-1:0] viol_flags,
  output logic [3:0]            viol_cmd
);

  localparam int HOLD_MAX = span_max(span_max(span_max(T_RC, T_RAS), T_WR + T_RP),
                                     span_max(span_max(T_RCD, T_RRD), T_RSC));
  localparam int W = $clog2(HOLD_MAX + 1);

  cmd_e cur;

  sdram_cmd_decode u_dec (
    .cs_n (cmd_cs_n),
    .ras_n(cmd_ras_n),
    .cas_n(cmd_cas_n),
    .we_n (cmd_we_n),
    .cmd  (cur)
  );

  logic c_act, c_rd, c_wr, c_rw, c_pre, c_ref, c_mrs, c_quiet;
  assign c_act   = (cur == CMD_ACT);
  assign c_rd    = (cur == CMD_RD);
  assign c_wr    = (cur == CMD_WR);
  assign c_rw    = c_rd | c_wr;
  assign c_pre   = (cur == CMD_PRE);
  assign c_ref   = (cur == CMD_REF);
  assign c_mrs   = (cur == CMD_MRS);
  assign c_quiet = (cur == CMD_NOP) | (cur == CMD_DESEL);

  logic [NUM_BANKS-1:0] open_b, rcd_b, ras_b, rp_b, rc_b, wr_b;
  logic [NUM_BANKS-1:0] hit_b, pre_tgt_b, act_do_b;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit_b[b]     = (cmd_bank == BANK_W'(b));
    assign pre_tgt_b[b] = c_pre & (cmd_a10 | hit_b[b]);
    assign act_do_b[b]  = c_act & hit_b[b] & ~open_b[b];

    sdram_bank_track #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
      .T_RC (T_RC),  .T_WR (T_WR),  .W   (W)
    ) u_trk (
      .clk     (clk),
      .rst     (rst),
      .do_act  (act_do_b[b]),
      .do_pre  (pre_tgt_b[b] & open_b[b]),
      .do_rd   (c_rd & hit_b[b] & open_b[b]),
      .do_wr   (c_wr & hit_b[b] & open_b[b]),
      .do_auto (cmd_a10),
      .do_ref  (c_ref),
      .is_open (open_b[b]),
      .rcd_busy(rcd_b[b]),
      .ras_busy(ras_b[b]),
      .rp_busy (rp_b[b]),
      .rc_busy (rc_b[b]),
      .wr_busy (wr_b[b])
    );
  end

  logic rrd_busy, rsc_busy;

  sdram_hold_timer #(.W(W)) u_rrd (
    .clk(clk), .rst(rst), .load(|act_do_b), .load_val(W'(T_RRD - 1)), .busy(rrd_busy)
  );

  sdram_hold_timer #(.W(W)) u_rsc (
    .clk(clk), .rst(rst), .load(c_mrs), .load_val(W'(T_RSC - 1)), .busy(rsc_busy)
  );

  logic sel_open;
  assign sel_open = open_b[cmd_bank];

  logic [RULE_COUNT-1:0] viol_now;

  always_comb begin
    viol_now             = '0;
    viol_now[RULE_RCD]   = c_rw & sel_open & rcd_b[cmd_bank];
    viol_now[RULE_RAS]   = |(pre_tgt_b & open_b & ras_b);
    viol_now[RULE_WR]    = |(pre_tgt_b & open_b & wr_b);
    viol_now[RULE_RP]    = c_act & ~sel_open & rp_b[cmd_bank];
    viol_now[RULE_RC]    = c_act & ~sel_open & rc_b[cmd_bank];
    viol_now[RULE_RRD]   = c_act & ~sel_open & rrd_busy;
    viol_now[RULE_STATE] = (c_rw & ~sel_open) | (c_act & sel_open);
    viol_now[RULE_IDLE]  = (c_mrs | c_ref) & (|open_b);
    viol_now[RULE_RSC]   = rsc_busy & ~c_quiet;
  end

  logic [RULE_COUNT-1:0] flags_q;
  cmd_e                  first_q;
  logic                  vec_empty;

  assign vec_empty = viol_clear | (flags_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      first_q <= CMD_NOP;
    end else begin
      flags_q <= (viol_clear ? '0 : flags_q) | viol_now;
      if ((|viol_now) && vec_empty) begin
        first_q <= cur;
      end
    end
  end

  assign bank_open  = open_b;
  assign viol_flags = flags_q;
  assign viol_cmd   = first_q;

endmodule

// File: rtl/sdram_rule_guard_chk.sv
`timescale 1ns/1ps
module sdram_rule_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int RULES     = 9
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_cs_n,
  input logic                 cmd_ras_n,
  input logic                 cmd_cas_n,
  input logic                 cmd_we_n,
  input logic                 viol_clear,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [RULES-1:0]     viol_flags,
  input logic [3:0]           viol_cmd
);

  logic p_act, p_mrs, p_nopish, p_keeps;
  assign p_act    = !cmd_cs_n && !cmd_ras_n && cmd_cas_n && cmd_we_n;
  assign p_mrs    = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n;
  assign p_nopish = cmd_cs_n || (cmd_ras_n && cmd_cas_n && cmd_we_n);
  assign p_keeps  = cmd_cs_n || (cmd_ras_n && cmd_cas_n) || (!cmd_ras_n && !cmd_cas_n);

  AST_OPEN_ONLY_BY_ACT: assert property (@(posedge clk) disable iff (rst)
    !p_act |=> ((bank_open & ~$past(bank_open)) == '0)); // R1

  AST_CLOSE_ONLY_BY_PRE_OR_AUTO: assert property (@(posedge clk) disable iff (rst)
    p_keeps |=> ((~bank_open & $past(bank_open)) == '0)); // R11

  AST_MRS_WITH_OPEN_BANK: assert property (@(posedge clk) disable iff (rst)
    (p_mrs && (bank_open != '0)) |=> viol_flags[7]); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !viol_clear |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags))); // R10

  AST_CLEAR_ON_QUIET: assert property (@(posedge clk) disable iff (rst)
    (viol_clear && p_nopish) |=> (viol_flags == '0)); // R10

  AST_CODE_IS_COMMAND: assert property (@(posedge clk) disable iff (rst)
    (viol_flags != '0) |-> (viol_cmd >= 4'd2 && viol_cmd <= 4'd8)); // R10

endmodule

bind sdram_rule_guard sdram_rule_guard_chk #(
  .NUM_BANKS(NUM_BANKS),
  .RULES    (9)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_cs_n  (cmd_cs_n),
  .cmd_ras_n (cmd_ras_n),
  .cmd_cas_n (cmd_cas_n),
  .cmd_we_n  (cmd_we_n),
  .viol_clear(viol_clear),
  .bank_open (bank_open),
  .viol_flags(viol_flags),
  .viol_cmd  (viol_cmd)
);

// File: tb/sdram_rule_guard_bench.sv
`timescale 1ns/1ps
module sdram_rule_guard_bench;

  localparam logic [3:0] K_NOP = 4'd0, K_DES = 4'd1, K_ACT = 4'd2, K_RD = 4'd3,
                         K_WR = 4'd4, K_PRE = 4'd5, K_REF = 4'd6, K_MRS = 4'd7,
                         K_BST = 4'd8;

  typedef struct packed {
    logic [3:0] code;
    logic [1:0] bank;
    logic       a10;
    logic [8:0] flags;
    logic [3:0] open;
  } step_t;

  localparam int NSTEP = 39;
  localparam step_t TBL [NSTEP] = '{
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0000}, // 0  R11
    '{K_ACT, 2'd0, 1'b0, 9'h000, 4'b0001}, // 1  R1
    '{K_ACT, 2'd1, 1'b0, 9'h010, 4'b0011}, // 2  R7
    '{K_RD,  2'd0, 1'b0, 9'h001, 4'b0011}, // 3  R3 one short
    '{K_RD,  2'd0, 1'b0, 9'h000, 4'b0011}, // 4  R3 boundary
    '{K_WR,  2'd1, 1'b0, 9'h000, 4'b0011}, // 5
    '{K_PRE, 2'd1, 1'b0, 9'h022, 4'b0001}, // 6  R4 tRAS and tWR
    '{K_ACT, 2'd1, 1'b0, 9'h00C, 4'b0011}, // 7  R5 R6
    '{K_MRS, 2'd0, 1'b0, 9'h080, 4'b0011}, // 8  R8
    '{K_RD,  2'd0, 1'b0, 9'h100, 4'b0011}, // 9  R9
    '{K_RD,  2'd2, 1'b0, 9'h040, 4'b0011}, // 10 R8 idle bank
    '{K_ACT, 2'd0, 1'b0, 9'h040, 4'b0011}, // 11 R8 open bank
    '{K_PRE, 2'd0, 1'b1, 9'h002, 4'b0000}, // 12 R2 all, R4
    '{K_REF, 2'd0, 1'b0, 9'h000, 4'b0000}, // 13
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0000}, // 14
    '{K_ACT, 2'd2, 1'b0, 9'h008, 4'b0100}, // 15 R6 after refresh
    '{K_BST, 2'd0, 1'b0, 9'h000, 4'b0100}, // 16 R11
    '{K_DES, 2'd0, 1'b0, 9'h000, 4'b0100}, // 17 R11
    '{K_WR,  2'd2, 1'b1, 9'h000, 4'b0000}, // 18 R2 auto-precharge
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0000}, // 19
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0000}, // 20
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0000}, // 21
    '{K_ACT, 2'd2, 1'b0, 9'h00C, 4'b0100}, // 22 R5 tWR+tRP
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0100}, // 23
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0100}, // 24
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0100}, // 25
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0100}, // 26
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0100}, // 27
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0100}, // 28
    '{K_PRE, 2'd2, 1'b0, 9'h000, 4'b0000}, // 29 R4 boundary
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0000}, // 30
    '{K_NOP, 2'd0, 1'b0, 9'h000, 4'b0000}, // 31
    '{K_ACT, 2'd2, 1'b0, 9'h000, 4'b0100}, // 32 R6 boundary
    '{K_RD,  2'd2, 1'b1, 9'h001, 4'b0000}, // 33 R3, R2
    '{K_ACT, 2'd3, 1'b0, 9'h000, 4'b1000}, // 34 R7 boundary
    '{K_MRS, 2'd0, 1'b0, 9'h080, 4'b1000}, // 35 R8
    '{K_BST, 2'd0, 1'b0, 9'h100, 4'b1000}, // 36 R9
    '{K_PRE, 2'd1, 1'b0, 9'h000, 4'b1000}, // 37 R2 idle precharge
    '{K_ACT, 2'd1, 1'b0, 9'h000, 4'b1010}  // 38 R2 no timer restart
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bank = '0;
  logic       a10 = 1'b0;
  logic       clr = 1'b0;
  logic [3:0] bank_open;
  logic [8:0] viol_flags;
  logic [3:0] viol_cmd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_rule_guard u_sdram_rule_guard (
    .clk       (clk),
    .rst       (rst),
    .cmd_cs_n  (cs_n),
    .cmd_ras_n (ras_n),
    .cmd_cas_n (cas_n),
    .cmd_we_n  (we_n),
    .cmd_bank  (bank),
    .cmd_a10   (a10),
    .viol_clear(clr),
    .bank_open (bank_open),
    .viol_flags(viol_flags),
    .viol_cmd  (viol_cmd)
  );

  task automatic put_cmd(input logic [3:0] code, input logic [1:0] bk, input logic ap);
    bank = bk;
    a10  = ap;
    cs_n = (code == K_DES);
    case (code)
      K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      K_RD:    {ras_n, cas_n, we_n} = 3'b101;
      K_WR:    {ras_n, cas_n, we_n} = 3'b100;
      K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      K_REF:   {ras_n, cas_n, we_n} = 3'b001;
      K_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      K_BST:   {ras_n, cas_n, we_n} = 3'b110;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [8:0] f);
    if (f[0]) return "R3";
    if (f[1] || f[5]) return "R4";
    if (f[2]) return "R5";
    if (f[3]) return "R6";
    if (f[4]) return "R7";
    if (f[6] || f[7]) return "R8";
    if (f[8]) return "R9";
    return "R11";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", "reset open", 16'(bank_open), 16'h0);
    check("R10", "reset flags", 16'(viol_flags), 16'h0);
    check("R10", "reset code", 16'(viol_cmd), 16'h0);
    rst = 1'b0;

    for (int s = 0; s < NSTEP; s++) begin
      put_cmd(TBL[s].code, TBL[s].bank, TBL[s].a10);
      clr = 1'b1;
      @(negedge clk);
      check(req_of(TBL[s].flags), $sformatf("step %0d flags", s),
            16'(viol_flags), 16'(TBL[s].flags));
      check("R1/R2", $sformatf("step %0d open", s), 16'(bank_open), 16'(TBL[s].open));
      if (TBL[s].flags != '0)
        check("R10", $sformatf("step %0d code", s), 16'(viol_cmd), 16'(TBL[s].code));
    end

    // R10: flags accumulate without clear, first code held
    clr = 1'b0;
    put_cmd(K_RD, 2'd0, 1'b0);
    @(negedge clk);
    check("R10", "sticky first", 16'(viol_flags), 16'h040);
    check("R10", "first code", 16'(viol_cmd), 16'(K_RD));
    put_cmd(K_MRS, 2'd0, 1'b0);
    @(negedge clk);
    check("R10", "sticky accumulate", 16'(viol_flags), 16'h0C0);
    check("R10", "code held", 16'(viol_cmd), 16'(K_RD));
    put_cmd(K_NOP, 2'd0, 1'b0);
    @(negedge clk);
    check("R10", "no clear keeps", 16'(viol_flags), 16'h0C0);
    clr = 1'b1;
    @(negedge clk);
    check("R10", "clear", 16'(viol_flags), 16'h000);
    clr = 1'b0;

    // R10: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R10", "rerun open", 16'(bank_open), 16'h0);
    check("R10", "rerun code", 16'(viol_cmd), 16'h0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule